// File: doc/BRIEF.md
# Audio Master-Clock Ratio Supervisor

This block sits beside the digital datapath of an audio converter and decides when that datapath may run. It counts master-clock cycles across each period of the left/right word clock and matches the count against six fixed oversampling ratios: 128, 192, 256, 384, 512 and 768 times the sample rate. It also counts bit-clock rising edges per word-clock period. After an active-low reset is released, it holds the datapath in initialisation for a fixed number of master-clock cycles. During that time, and until a supported ratio has been confirmed, it asks the output stage to sit at midscale (bipolar zero).

Once locked, the block watches for the word clock slipping against the master clock. It measures the slip in bit-clock periods, compares each period's bit count with the count recorded at lock, and checks for a missing word clock. Any of these faults drops lock at once, restarts the initialisation count and forces midscale again. Normal operation comes back only after a fresh confirmation of the ratio.

Top module: `audio_clock_supervisor`

## Requirements
- R1: While `resetN` is low, `initHold` and `forceMidscale` are 1, `ratioValid` is 0 and `ratioCode` is 0; assertion of `resetN` takes effect without waiting for a clock edge.
- R2: The first word-clock rising edge after reset only starts a measurement. A period is the number of master-clock cycles between two rising edges. `ratioValid` rises at the edge that closes the second of two consecutive periods matching the same ratio. `ratioCode` then reads 0, 1, 2, 3, 4, 5 for 128, 192, 256, 384, 512, 768.
- R3: A period matches a ratio when it lies within ±2 cycles of the nominal count. A word clock whose period matches no ratio leaves `ratioValid` at 0 and `forceMidscale` and `initHold` at 1 indefinitely.
- R4: Counting from the first master-clock edge after `resetN` rises, `initHold` and `forceMidscale` fall at edge max(1024, edge of lock) and not earlier.
- R5: While locked, a word-clock period whose bit-clock count differs from the count of the locking period by more than 6 drops `ratioValid` and raises `forceMidscale` and `initHold` at the master-clock edge that sees the closing word-clock rise.
- R6: While locked, a single word-clock slip of 6 bit-clock periods or fewer leaves `ratioValid`, `forceMidscale` and `initHold` unchanged.
- R7: While locked, if 771 master-clock cycles (768 + 2 + 1) pass without a word-clock rise, lock drops at the edge where the count reaches that limit, that is 771 edges after the last rise.
- R8: After a loss of lock, the 1024-cycle initialisation restarts from the loss edge. The loss edge counts as the first edge of a new measurement, so relock needs two new matching periods.
- R9: After the master-to-word ratio changes while locked, the block drops lock and relocks, reporting the new ratio code.
- R10: Consecutive periods that match different ratios never produce a lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| masterClk | input | 1 | Free-running master clock; all logic runs on its rising edge |
| resetN | input | 1 | Active-low reset (power-on or external); its release starts initialisation |
| wordClk | input | 1 | Left/right word clock, synchronous to the master clock |
| bitClk | input | 1 | Serial bit clock, used to measure slip |
| ratioCode | output | 3 | Detected ratio: 0..5 for 128/192/256/384/512/768; 0 when not locked |
| ratioValid | output | 1 | A supported ratio has been confirmed and is being tracked |
| initHold | output | 1 | Holds the datapath in initialisation |
| forceMidscale | output | 1 | Requests the output stage to sit at bipolar zero |

## Verification
Suppose the period counter or the candidate register held a wrong value. It would show at the ports as `ratioValid` rising one word period early or late, or `ratioCode` naming the neighbouring ratio, at the exact edge predicted from the stimulus period. A wrong initialisation count moves the fall of `initHold` away from edge 1024 after release, or shortens the hold after a slip. Faults in the reference bit count or the drift comparator show within one word period of a slip: a 7-bit-clock slip that does not raise `forceMidscale` at its closing edge, or a 6-bit-clock slip that does raise it. A faulty timeout shows 771 cycles after the last word-clock rise.

// File: rtl/acs_pkg.sv
package acs_pkg;

  localparam int RATIO_COUNT = 6;
  localparam int CODE_W      = 3;

  typedef logic [CODE_W-1:0] ratio_code_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadRef;   // capture the current bit count as the slip reference
    logic dropRef;   // forget the slip reference
  } acs_ctl_t;

  // datapath -> control measurement strobes
  typedef struct packed {
    logic        wordEdge;       // word clock rose on this cycle
    logic        periodHit;      // closing period matches a supported ratio
    ratio_code_t periodCode;     // which ratio matched
    logic        bitDrift;       // closing period slipped beyond the limit
    logic        periodTimeout;  // period counter reached its ceiling
  } acs_meas_t;

  // ratio index -> multiple of the ratio unit (unit 64 gives 128..768)
  function automatic int ratioMultiple(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 6;
      4:       return 8;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/acs_meter.sv
module acs_meter
  import acs_pkg::*;
#(
  parameter int RATIO_UNIT  = 64,
  parameter int TOLERANCE   = 2,
  parameter int DRIFT_LIMIT = 6,
  parameter int MAX_PERIOD  = 771,
  parameter int CNT_W       = 10
) (
  input  logic      masterClk,
  input  logic      resetN,
  input  logic      wordClk,
  input  logic      bitClk,
  input  acs_ctl_t  ctl,
  output acs_meas_t meas
);

  logic             wcPrev, bcPrev;
  logic             wcRise, bcRise;
  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] refBits;
  logic             refValid;
  logic [CNT_W-1:0] bitDiff;
  logic [RATIO_COUNT-1:0] hitVec;
  ratio_code_t      hitCode;

  assign wcRise = wordClk & ~wcPrev;
  assign bcRise = bitClk & ~bcPrev;

  always_ff @(posedge masterClk or negedge resetN) begin
    if (!resetN) begin
      wcPrev    <= 1'b0;
      bcPrev    <= 1'b0;
      periodCnt <= '0;
      bitCnt    <= '0;
      refBits   <= '0;
      refValid  <= 1'b0;
    end else begin
      wcPrev <= wordClk;
      bcPrev <= bitClk;

      if (wcRise)
        periodCnt <= CNT_W'(1);
      else if (periodCnt != CNT_W'(MAX_PERIOD))
        periodCnt <= periodCnt + 1'b1;

      if (wcRise)
        bitCnt <= {{(CNT_W-1){1'b0}}, bcRise};
      else if (bcRise && (bitCnt != '1))
        bitCnt <= bitCnt + 1'b1;

      if (ctl.dropRef) begin
        refValid <= 1'b0;
      end else if (ctl.loadRef) begin
        refValid <= 1'b1;
        refBits  <= bitCnt;
      end
    end
  end

  // one window comparator per supported ratio
  for (genvar g = 0; g < RATIO_COUNT; g++) begin : g_ratio
    localparam int NOMINAL = ratioMultiple(g) * RATIO_UNIT;
    assign hitVec[g] = (int'(periodCnt) >= NOMINAL - TOLERANCE) &&
                       (int'(periodCnt) <= NOMINAL + TOLERANCE);
  end

  always_comb begin
    hitCode = '0;
    for (int i = 0; i < RATIO_COUNT; i++)
      if (hitVec[i]) hitCode = CODE_W'(i);
  end

  assign bitDiff = (bitCnt >= refBits) ? (bitCnt - refBits) : (refBits - bitCnt);

  always_comb begin
    meas.wordEdge      = wcRise;
    meas.periodHit     = |hitVec;
    meas.periodCode    = hitCode;
    meas.bitDrift      = refValid && (bitDiff > CNT_W'(DRIFT_LIMIT));
    meas.periodTimeout = (periodCnt == CNT_W'(MAX_PERIOD));
  end

endmodule

// File: rtl/acs_sequencer.sv
module acs_sequencer
  import acs_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int INIT_W      = 11
) (
  input  logic        masterClk,
  input  logic        resetN,
  input  acs_meas_t   meas,
  output acs_ctl_t    ctl,
  output ratio_code_t ratioCode,
  output logic        ratioValid,
  output logic        initHold,
  output logic        forceMidscale
);

  logic              armed;
  logic              candValid;
  ratio_code_t       candCode;
  logic              locked;
  ratio_code_t       lockCode;
  logic [INIT_W-1:0] initCnt;
  logic              initDone;
  logic              lockNow;
  logic              lossNow;

  assign initDone = (initCnt == INIT_W'(INIT_CYCLES));

  // second consecutive period agreeing with the candidate
  assign lockNow = meas.wordEdge && armed && !locked && meas.periodHit &&
                   candValid && (candCode == meas.periodCode);

  // loss: missing word clock, excessive slip, or a different ratio
  assign lossNow = locked &&
                   (meas.periodTimeout ||
                    (meas.wordEdge && (meas.bitDrift ||
                     (meas.periodHit && (meas.periodCode != lockCode)))));

  always_ff @(posedge masterClk or negedge resetN) begin
    if (!resetN) begin
      armed     <= 1'b0;
      candValid <= 1'b0;
      candCode  <= '0;
      locked    <= 1'b0;
      lockCode  <= '0;
      initCnt   <= '0;
    end else begin
      if (lossNow)
        initCnt <= '0;
      else if (!initDone)
        initCnt <= initCnt + 1'b1;

      if (lossNow) begin
        locked    <= 1'b0;
        candValid <= 1'b0;
        armed     <= meas.wordEdge;
      end else if (meas.wordEdge) begin
        if (!armed) begin
          armed <= 1'b1;
        end else if (lockNow) begin
          locked    <= 1'b1;
          lockCode  <= meas.periodCode;
          candValid <= 1'b0;
        end else if (!locked) begin
          candValid <= meas.periodHit;
          candCode  <= meas.periodCode;
        end
      end
    end
  end

  always_comb begin
    ctl.loadRef = lockNow;
    ctl.dropRef = lossNow;
  end

  assign ratioValid    = locked;
  assign ratioCode     = locked ? lockCode : '0;
  assign initHold      = ~(locked & initDone);
  assign forceMidscale = ~(locked & initDone);

endmodule

// File: rtl/audio_clock_supervisor.sv
module audio_clock_supervisor
  import acs_pkg::*;
#(
  parameter int RATIO_UNIT  = 64,
  parameter int TOLERANCE   = 2,
  parameter int DRIFT_LIMIT = 6,
  parameter int INIT_CYCLES = 1024
) (
  input  logic              masterClk,
  input  logic              resetN,
  input  logic              wordClk,
  input  logic              bitClk,
  output logic [CODE_W-1:0] ratioCode,
  output logic              ratioValid,
  output logic              initHold,
  output logic              forceMidscale
);

  localparam int MAX_RATIO  = ratioMultiple(RATIO_COUNT-1) * RATIO_UNIT;
  localparam int MAX_PERIOD = MAX_RATIO + TOLERANCE + 1;
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);
  localparam int INIT_W     = $clog2(INIT_CYCLES + 1);

  acs_ctl_t  ctl;
  acs_meas_t meas;

  acs_meter #(
    .RATIO_UNIT (RATIO_UNIT),
    .TOLERANCE  (TOLERANCE),
    .DRIFT_LIMIT(DRIFT_LIMIT),
    .MAX_PERIOD (MAX_PERIOD),
    .CNT_W      (CNT_W)
  ) u_meter (
    .masterClk(masterClk),
    .resetN   (resetN),
    .wordClk  (wordClk),
    .bitClk   (bitClk),
    .ctl      (ctl),
    .meas     (meas)
  );

  acs_sequencer #(
    .INIT_CYCLES(INIT_CYCLES),
    .INIT_W     (INIT_W)
  ) u_seq (
    .masterClk    (masterClk),
    .resetN       (resetN),
    .meas         (meas),
    .ctl          (ctl),
    .ratioCode    (ratioCode),
    .ratioValid   (ratioValid),
    .initHold     (initHold),
    .forceMidscale(forceMidscale)
  );

endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int INIT_CYCLES = 1024,
  parameter int MAX_PERIOD  = 771
) (
  input logic       masterClk,
  input logic       resetN,
  input logic       wordClk,
  input logic [2:0] ratioCode,
  input logic       ratioValid,
  input logic       initHold,
  input logic       forceMidscale
);

  logic        wcSeen;
  logic [31:0] holdCnt;
  logic [31:0] gapCnt;

  always_ff @(posedge masterClk or negedge resetN) begin
    if (!resetN) begin
      wcSeen  <= 1'b0;
      holdCnt <= '0;
      gapCnt  <= '0;
    end else begin
      wcSeen <= wordClk;
      if (!initHold)
        holdCnt <= '0;
      else if (holdCnt < 32'(INIT_CYCLES + 1))
        holdCnt <= holdCnt + 1'b1;
      if (wordClk && !wcSeen)
        gapCnt <= '0;
      else if (gapCnt < 32'(MAX_PERIOD + 8))
        gapCnt <= gapCnt + 1'b1;
    end
  end

  // R2
  code_range_chk: assert property (@(posedge masterClk) disable iff (!resetN)
    ratioValid |-> (ratioCode < 3'd6));

  // R3
  mid_when_unlocked_chk: assert property (@(posedge masterClk) disable iff (!resetN)
    !ratioValid |-> (forceMidscale && initHold && ratioCode == 3'd0));

  // R4
  init_length_chk: assert property (@(posedge masterClk) disable iff (!resetN)
    $fell(initHold) |-> (holdCnt >= 32'(INIT_CYCLES)));

  // R7
  missing_word_chk: assert property (@(posedge masterClk) disable iff (!resetN)
    (gapCnt > 32'(MAX_PERIOD + 1)) |-> !ratioValid);

  // R9
  code_hold_chk: assert property (@(posedge masterClk) disable iff (!resetN)
    (ratioValid && $past(ratioValid)) |-> $stable(ratioCode));

endmodule

bind audio_clock_supervisor acs_checker #(
  .INIT_CYCLES(INIT_CYCLES),
  .MAX_PERIOD (MAX_PERIOD)
) u_acs_checker (
  .masterClk    (masterClk),
  .resetN       (resetN),
  .wordClk      (wordClk),
  .ratioCode    (ratioCode),
  .ratioValid   (ratioValid),
  .initHold     (initHold),
  .forceMidscale(forceMidscale)
);

// File: tb/audio_clock_supervisor_test.sv
module audio_clock_supervisor_test;

  logic       masterClk = 1'b0;
  logic       resetN = 1'b0;
  logic       wordClk = 1'b0;
  logic       bitClk = 1'b0;
  logic [2:0] ratioCode;
  logic       ratioValid;
  logic       initHold;
  logic       forceMidscale;

  audio_clock_supervisor uut (
    .masterClk    (masterClk),
    .resetN       (resetN),
    .wordClk      (wordClk),
    .bitClk       (bitClk),
    .ratioCode    (ratioCode),
    .ratioValid   (ratioValid),
    .initHold     (initHold),
    .forceMidscale(forceMidscale)
  );

  always #5 masterClk = ~masterClk;

  int nChecks = 0;
  int nErrors = 0;
  int relCyc = 0;
  int totalCyc = 0;
  bit finished = 0;

  // stimulus generator state
  bit genOn = 0, genAlt = 0, altSel = 0;
  int genP = 256, genP2 = 256, genBp = 4;
  int ph = 0, frameLen = 256, extraReq = 0;
  bit slipWanted = 0, slipFrame = 0, chkNext = 0, lossSeen = 0;
  int lossRel = 0, riseRel = 0;
  bit monOn = 0, sawMid = 0;

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  always @(posedge masterClk) begin
    relCyc = relCyc + 1;
    totalCyc = totalCyc + 1;
    if (totalCyc > 190000 && !finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual %0d expected %0d", totalCyc, 0);
      finishRun();
    end
  end

  always @(negedge masterClk) begin
    if (monOn && forceMidscale) sawMid = 1;
  end

  // word and bit clock generator; drives away from the active edge
  always @(negedge masterClk) begin
    if (chkNext) begin
      chkNext = 0;
      lossSeen = 1;
      lossRel = relCyc;
      checkEq("R5 forceMidscale at slip edge", int'(forceMidscale), 1);
      checkEq("R5 ratioValid at slip edge", int'(ratioValid), 0);
      checkEq("R5 initHold at slip edge", int'(initHold), 1);
    end
    if (!genOn) begin
      ph = 0;
      wordClk = 1'b0;
      bitClk = 1'b0;
    end else begin
      if (ph == 0) begin
        if (slipFrame) begin slipFrame = 0; chkNext = 1; end
        frameLen = (genAlt && altSel) ? genP2 : genP;
        altSel = ~altSel;
        if (extraReq != 0) begin
          frameLen = frameLen + extraReq;
          extraReq = 0;
          slipFrame = slipWanted;
          slipWanted = 0;
        end
        riseRel = relCyc;
      end
      wordClk = (ph < frameLen / 2);
      bitClk = ((ph % genBp) < (genBp / 2));
      ph = ph + 1;
      if (ph >= frameLen) ph = 0;
    end
  end

  task automatic startRun(input int p, input int bp);
    @(posedge masterClk);
    #1;
    resetN = 1'b0;
    genOn = 0; genAlt = 0; altSel = 0; extraReq = 0;
    repeat (3) @(posedge masterClk);
    #1;
    genP = p; genP2 = p; genBp = bp;
    @(posedge masterClk);
    #1;
    resetN = 1'b1;
    genOn = 1;
    relCyc = 0;
  endtask

  task automatic waitRel(input int n);
    do @(negedge masterClk); while (relCyc < n);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge masterClk);
    checkEq("R1 initHold in reset", int'(initHold), 1);
    checkEq("R1 forceMidscale in reset", int'(forceMidscale), 1);
    checkEq("R1 ratioValid in reset", int'(ratioValid), 0);
    checkEq("R1 ratioCode in reset", int'(ratioCode), 0);

    // R2 / R4: sweep all six ratios with exact lock and release edges
    for (int i = 0; i < 6; i++) begin
      int mult, p, lockAt;
      mult = (i == 0) ? 2 : (i == 1) ? 3 : (i == 2) ? 4 : (i == 3) ? 6 : (i == 4) ? 8 : 12;
      p = 64 * mult;
      lockAt = 1 + 2 * p;
      startRun(p, mult);
      waitRel(lockAt - 1);
      checkEq("R2 ratioValid before second period", int'(ratioValid), 0);
      checkEq("R4 initHold before lock", int'(initHold), 1);
      waitRel(lockAt);
      checkEq("R2 ratioValid at lock edge", int'(ratioValid), 1);
      checkEq("R2 ratioCode at lock", int'(ratioCode), i);
      if (lockAt < 1024) begin
        checkEq("R4 initHold during init after lock", int'(initHold), 1);
        waitRel(1023);
        checkEq("R4 initHold at edge 1023", int'(initHold), 1);
        checkEq("R4 forceMidscale at edge 1023", int'(forceMidscale), 1);
        waitRel(1024);
        checkEq("R4 initHold at edge 1024", int'(initHold), 0);
        checkEq("R4 forceMidscale at edge 1024", int'(forceMidscale), 0);
      end else begin
        checkEq("R4 initHold released at late lock", int'(initHold), 0);
        checkEq("R4 forceMidscale released at late lock", int'(forceMidscale), 0);
      end
    end

    // R3: tolerance window edges
    startRun(258, 4);
    waitRel(3000);
    checkEq("R3 258 accepted", int'(ratioValid), 1);
    checkEq("R3 258 code", int'(ratioCode), 2);
    startRun(126, 2);
    waitRel(3000);
    checkEq("R3 126 accepted", int'(ratioValid), 1);
    checkEq("R3 126 code", int'(ratioCode), 0);
    startRun(766, 12);
    waitRel(3000);
    checkEq("R3 766 code", int'(ratioCode), 5);
    startRun(259, 4);
    waitRel(4000);
    checkEq("R3 259 rejected valid", int'(ratioValid), 0);
    checkEq("R3 259 rejected midscale", int'(forceMidscale), 1);
    startRun(765, 12);
    waitRel(4000);
    checkEq("R3 765 rejected valid", int'(ratioValid), 0);
    startRun(300, 4);
    waitRel(4000);
    checkEq("R3 300 rejected valid", int'(ratioValid), 0);
    checkEq("R3 300 rejected hold", int'(initHold), 1);

    // R10: alternating ratios never lock
    startRun(256, 4);
    genAlt = 1; genP2 = 384;
    waitRel(5000);
    checkEq("R10 alternating periods valid", int'(ratioValid), 0);
    checkEq("R10 alternating periods midscale", int'(forceMidscale), 1);

    // R6 / R5 / R8: slips
    startRun(256, 4);
    waitRel(1100);
    checkEq("R6 running before slip", int'(initHold), 0);
    sawMid = 0; monOn = 1;
    @(posedge masterClk); #1;
    extraReq = 24;                       // 6 bit clocks of 4 cycles
    repeat (1200) @(posedge masterClk);
    checkEq("R6 six-bit slip no midscale", int'(sawMid), 0);
    checkEq("R6 six-bit slip still valid", int'(ratioValid), 1);
    monOn = 0;
    @(posedge masterClk); #1;
    lossSeen = 0;
    slipWanted = 1;
    extraReq = 28;                       // 7 bit clocks
    while (!lossSeen) @(posedge masterClk);
    waitRel(lossRel + 511);
    checkEq("R8 no relock after one period", int'(ratioValid), 0);
    waitRel(lossRel + 512);
    checkEq("R8 relock after two periods", int'(ratioValid), 1);
    waitRel(lossRel + 1023);
    checkEq("R8 hold restarted at edge 1023", int'(initHold), 1);
    waitRel(lossRel + 1024);
    checkEq("R8 hold released at edge 1024", int'(initHold), 0);
    checkEq("R8 code after relock", int'(ratioCode), 2);

    // R7: missing word clock
    startRun(256, 4);
    waitRel(1100);
    do @(posedge masterClk); while (ph != 1);
    #1;
    genOn = 0;
    begin
      int edgeAt;
      edgeAt = riseRel + 1;
      waitRel(edgeAt + 770);
      checkEq("R7 still valid at 770", int'(ratioValid), 1);
      waitRel(edgeAt + 771);
      checkEq("R7 valid dropped at 771", int'(ratioValid), 0);
      checkEq("R7 midscale at 771", int'(forceMidscale), 1);
    end

    // R9: ratio change while locked
    startRun(256, 4);
    waitRel(1100);
    checkEq("R9 locked at 256", int'(ratioCode), 2);
    sawMid = 0; monOn = 1;
    @(posedge masterClk); #1;
    genP = 512; genP2 = 512; genBp = 8;
    waitRel(relCyc + 6000);
    @(posedge masterClk);
    checkEq("R9 lock dropped on change", int'(sawMid), 1);
    monOn = 0;
    @(negedge masterClk);
    checkEq("R9 relocked valid", int'(ratioValid), 1);
    checkEq("R9 new code", int'(ratioCode), 4);
    checkEq("R9 running after relock", int'(initHold), 0);

    // R1: reset while running acts at once
    @(posedge masterClk); #1;
    resetN = 1'b0;
    @(negedge masterClk);
    checkEq("R1 mid-run reset valid", int'(ratioValid), 0);
    checkEq("R1 mid-run reset code", int'(ratioCode), 0);
    checkEq("R1 mid-run reset hold", int'(initHold), 1);
    checkEq("R1 mid-run reset midscale", int'(forceMidscale), 1);

    finishRun();
  end

endmodule